// File: doc/BRIEF.md
# Power Supply Event Interrupt Controller

This block collects power-supply events from a small microcontroller subsystem and turns them into one interrupt request. The event sources are a change of the switched supply rail from mains to battery (switchover), a change back (restore), an external DC-input change, a battery event (low level or new measurement) and a line-voltage sag. The analog comparators, converters and the supply switch itself sit outside. Each arrives here as a one-cycle digital pulse, except the supply source, which arrives as a level. The block finds the switchover and restore events itself by watching that level for edges.

Every event sets a sticky flag whether or not its interrupt is enabled. Software reads the flags, decides what to do and clears each flag by writing 0 to its bit. A separate enable register chooses which flags can raise the interrupt. A status register reports the live supply source, so firmware can tell which rail it is running from no matter what the flags hold. Access goes through a byte-wide bus with a combinational read port.

Top module: `pwr_evt_irq`

## Requirements
- R1: A pulse on `dcin_evt_i`, `bat_evt_i` or `sag_evt_i` at a clock edge sets flag bit 2, 3 or 4 of the flag register (address 0xF8) from that edge on, whatever the enable register holds.
- R2: When `src_main_i` is sampled at 0 at an edge after it was 1 at the edge before, flag bit 0 (switchover) is set. A change from 0 to 1 sets flag bit 1 (restore). No edge is detected at the first clock edge after reset.
- R3: Flags stay set until software writes 0 to that bit at address 0xF8. Writing 1 to a flag bit leaves it unchanged.
- R4: If an event and a clearing write of its flag fall on the same edge, the flag ends up set.
- R5: The enable register at address 0xEC holds bits 4:0 (same bit order as the flags) and reads back what was written.
- R6: `irq_o` is 1 in the cycle after an edge at which any flag bit and its enable bit were both 1 before the edge, and 0 otherwise.
- R7: A read of address 0xF4 returns bit 6 equal to the live `src_main_i` (1 means mains, 0 means battery), with all other bits 0.
- R8: Bits 7:5 of the flag and enable registers read 0, and any other address reads 0x00.
- R9: After reset the flag register, the enable register and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_main_i | input | 1 | Live supply source, 1 = mains, 0 = battery |
| dcin_evt_i | input | 1 | DC-input change pulse |
| bat_evt_i | input | 1 | Battery event pulse |
| sag_evt_i | input | 1 | Line sag pulse |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach is an event landing on the same edge as the write that clears its flag, with the supply-source edges adding a derived event that software cannot pulse directly. The stimulus sets up both cases on purpose: once with a sag pulse, and once with a source toggle timed to a clearing write. The random phase then produces thousands of mixed cycles in which sparse pulses, source flips, clearing writes with random masks and enable writes overlap. Every cycle's read data and interrupt are compared against a bench model.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
    localparam int NUM_EVT   = 5;
    localparam int BUS_W     = 8;
    localparam int EVT_SWOV  = 0;
    localparam int EVT_REST  = 1;
    localparam int EVT_DCIN  = 2;
    localparam int EVT_BAT   = 3;
    localparam int EVT_SAG   = 4;

    typedef struct packed {
        logic [NUM_EVT-1:0] en;
        logic               irq;
    } ctrl_state_t;

    typedef struct packed {
        logic armed;
        logic src;
    } src_state_t;
endpackage

// File: rtl/pwr_src_mon.sv
module pwr_src_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    output logic to_bat_o,
    output logic to_main_o
);
    import pwr_evt_pkg::*;

    src_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.src   = src_i;
        st_d.armed = 1'b1;
        to_bat_o   = st_q.armed &&  st_q.src && !src_i;
        to_main_o  = st_q.armed && !st_q.src &&  src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwr_flag_bank.sv
module pwr_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            if (clr_we_i) flag_d[g] = (flag_q[g] & keep_i[g]) | evt_i[g];
            else          flag_d[g] = flag_q[g] | evt_i[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/pwr_evt_irq.sv
module pwr_evt_irq #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  EN_ADDR   = 8'hEC,
    parameter logic [7:0]  FLAG_ADDR = 8'hF8,
    parameter logic [7:0]  STAT_ADDR = 8'hF4,
    parameter int          SRC_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_main_i,
    input  logic              dcin_evt_i,
    input  logic              bat_evt_i,
    input  logic              sag_evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);
    import pwr_evt_pkg::*;

    localparam int PAD_W = BUS_W - NUM_EVT;

    logic                to_bat, to_main;
    logic [NUM_EVT-1:0]  evt_vec;
    logic [NUM_EVT-1:0]  flag_q;
    logic                flag_we;
    ctrl_state_t         cs_d, cs_q;
    logic [NUM_EVT-1:0]  en_q;

    pwr_src_mon u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_main_i),
        .to_bat_o  (to_bat),
        .to_main_o (to_main)
    );

    always_comb begin
        evt_vec           = '0;
        evt_vec[EVT_SWOV] = to_bat;
        evt_vec[EVT_REST] = to_main;
        evt_vec[EVT_DCIN] = dcin_evt_i;
        evt_vec[EVT_BAT]  = bat_evt_i;
        evt_vec[EVT_SAG]  = sag_evt_i;
    end

    assign flag_we = wr_en_i && (addr_i == ADDR_W'(FLAG_ADDR));

    pwr_flag_bank #(.N(NUM_EVT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_vec),
        .clr_we_i (flag_we),
        .keep_i   (wdata_i[NUM_EVT-1:0]),
        .flag_o   (flag_q)
    );

    always_comb begin
        cs_d     = cs_q;
        cs_d.irq = |(flag_q & cs_q.en);
        if (wr_en_i && (addr_i == ADDR_W'(EN_ADDR)))
            cs_d.en = wdata_i[NUM_EVT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign en_q  = cs_q.en;
    assign irq_o = cs_q.irq;

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(EN_ADDR))        rdata_o = {{PAD_W{1'b0}}, cs_q.en};
        else if (addr_i == ADDR_W'(FLAG_ADDR)) rdata_o = {{PAD_W{1'b0}}, flag_q};
        else if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o[SRC_BIT] = src_main_i;
    end
endmodule

// File: rtl/pwr_evt_irq_chk.sv
module pwr_evt_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dcin_evt_i,
    input logic       sag_evt_i,
    input logic [7:0] addr_i,
    input logic       wr_en_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic       irq_o,
    input logic [4:0] flag_q,
    input logic [4:0] en_q
);
    // R1
    dcin_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcin_evt_i |=> flag_q[2]);

    // R4
    sag_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_evt_i && wr_en_i && addr_i == 8'hF8 && !wdata_i[4]) |=> flag_q[4]);

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == 8'hF8) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R6
    irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q) != 5'd0) |=> irq_o);

    // R6
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q) == 5'd0) |=> !irq_o);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 8'hEC || addr_i == 8'hF8) |-> (rdata_o[7:5] == 3'b000));
endmodule

bind pwr_evt_irq pwr_evt_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dcin_evt_i (dcin_evt_i),
    .sag_evt_i  (sag_evt_i),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .flag_q     (flag_q),
    .en_q       (en_q)
);

// File: tb/pwr_evt_irq_tb.sv
module pwr_evt_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_main_i = 1'b1;
    logic       dcin_evt_i = 1'b0, bat_evt_i = 1'b0, sag_evt_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic       wr_en_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0] m_flag = '0, m_en = '0;
    logic       m_irq = 1'b0, m_src = 1'b0, m_armed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_evt_irq u_dut (
        .clk(clk), .rst_n(rst_n), .src_main_i(src_main_i),
        .dcin_evt_i(dcin_evt_i), .bat_evt_i(bat_evt_i), .sag_evt_i(sag_evt_i),
        .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a == 8'hEC) return {3'b000, m_en};
        if (a == 8'hF8) return {3'b000, m_flag};
        if (a == 8'hF4) return {1'b0, src_main_i, 6'b0};
        return 8'h00;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model update at a rising edge, from inputs present at that edge
    task automatic model_edge();
        logic [4:0] ev;
        ev = {sag_evt_i, bat_evt_i, dcin_evt_i,
              m_armed && !m_src && src_main_i,
              m_armed && m_src && !src_main_i};
        m_irq = |(m_flag & m_en);
        if (wr_en_i && addr_i == 8'hF8) m_flag = (m_flag & wdata_i[4:0]) | ev;
        else                            m_flag = m_flag | ev;
        if (wr_en_i && addr_i == 8'hEC) m_en = wdata_i[4:0];
        m_src = src_main_i;
        m_armed = 1'b1;
    endtask

    // one clock: inputs already driven, advance, then clear pulses and strobes
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        dcin_evt_i = 0; bat_evt_i = 0; sag_evt_i = 0; wr_en_i = 0;
    endtask

    task automatic read_chk(string req, logic [7:0] a);
        addr_i = a; #1;
        check(req, rdata_o, exp_read(a));
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        read_chk("R9", 8'hF8);
        read_chk("R9", 8'hEC);
        check("R9", {7'b0, irq_o}, 8'h00);
        rst_n = 1; step();
        // R2 no edge on first cycle: src held at 1, flags still 0
        read_chk("R2", 8'hF8);
        // R1 events set flags with enables off
        dcin_evt_i = 1; step(); bat_evt_i = 1; step(); sag_evt_i = 1; step();
        read_chk("R1", 8'hF8);
        check("R6", {7'b0, irq_o}, 8'h00);
        // R3 writing ones keeps flags
        wr(8'hF8, 8'hFF);
        read_chk("R3", 8'hF8);
        // R2 switchover then restore
        src_main_i = 0; step();
        read_chk("R2", 8'hF8);
        read_chk("R7", 8'hF4);
        src_main_i = 1; step();
        read_chk("R2", 8'hF8);
        read_chk("R7", 8'hF4);
        // R5 enable write and read back, R8 reserved bits
        wr(8'hEC, 8'hFF);
        read_chk("R5", 8'hEC);
        read_chk("R8", 8'h33);
        step();
        check("R6", {7'b0, irq_o}, 8'h01);
        // R3 clear all flags
        wr(8'hF8, 8'h00);
        read_chk("R3", 8'hF8);
        step();
        check("R6", {7'b0, irq_o}, 8'h00);
        // R4 sag pulse same edge as clearing write
        sag_evt_i = 1; wr(8'hF8, 8'h00);
        read_chk("R4", 8'hF8);
        // R4 source edge same edge as clearing write
        src_main_i = 0; wr(8'hF8, 8'h00);
        read_chk("R4", 8'hF8);
        src_main_i = 1; step();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            dcin_evt_i = (r[3:0] == 0);
            bat_evt_i  = (r[7:4] == 0);
            sag_evt_i  = (r[11:8] == 0);
            if (r[15:12] == 0) src_main_i = ~src_main_i;
            wr_en_i = (r[18:16] == 0);
            case (r[20:19])
                2'd0: addr_i = 8'hEC;
                2'd1: addr_i = 8'hF8;
                2'd2: addr_i = 8'hF4;
                default: addr_i = r[31:24];
            endcase
            wdata_i = $urandom;
            step();
            check("R6", {7'b0, irq_o}, {7'b0, m_irq});
            read_chk("R1", 8'hF8);
            read_chk("R5", 8'hEC);
            read_chk("R7", 8'hF4);
            read_chk("R8", r[31:24]);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule